// File: doc/BRIEF.md
# DTMF Tone Pair Decoder

This block turns the two squared-up outputs of a dual-tone receiver front end into a keypad digit. One input carries the low-group (row) tone and the other the high-group (column) tone, both already band-limited and limited to logic levels. Each input is timed against the reference clock: the block counts clock cycles between rising edges, adds up four consecutive periods and compares that sum with a tolerance window around each nominal frequency of its group.

When both inputs sit inside a window at the same time, the block raises an early-steering flag and presents a 4-bit digit code for the pair. The flag drops as soon as either input stops matching, whether the tone drifts off frequency, leaves the band or stops toggling. The code is held between pairs, so downstream steering and latching logic can sample it at leisure.

Top module: `dtmf_pair_decoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, `est_o` becomes 0 and `code_o` becomes 4'b0000.
- R2: On the low-group input, the rows are numbered 0 to 3 for 697, 770, 852 and 941 Hz.
- R3: On the high-group input, the columns are numbered 0 to 3 for 1209, 1336, 1477 and 1633 Hz.
- R4: An input is judged on the sum of 4 consecutive periods measured in reference-clock cycles. It matches a tone only when that average lies within ±2.5% of the tone's nominal frequency. A tone about 1.4% off is accepted and one about 5% off is rejected.
- R5: `est_o` is high only while both inputs match a tone. It rises one cycle after the second input starts to match.
- R6: Rows 0 to 2 with columns 0 to 2 give the digits 1 to 9 in keypad order. The code is row*3 + column + 1 in binary.
- R7: Row 3 gives code 4'b1011 with column 0 (star), 4'b1010 with column 1 (digit 0) and 4'b1100 with column 2 (hash).
- R8: Column 3 gives codes 4'b1101, 4'b1110, 4'b1111 and 4'b0000 for rows 0, 1, 2 and 3 (A to D).
- R9: An input with no rising edge for 8 ms of reference clock counts as not matching, and `est_o` falls. Before that time a stalled input keeps its last result.
- R10: `code_o` changes only in the cycle where `est_o` rises. If the matched pair changes without a gap, `est_o` goes low for at least one cycle and then rises with the new code.
- R11: A tone outside every window of its group clears `est_o` and leaves `code_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock (3.579545 MHz by default) |
| rst_n | input | 1 | Synchronous active-low reset |
| tone_lo_i | input | 1 | Limited low-group tone, asynchronous |
| tone_hi_i | input | 1 | Limited high-group tone, asynchronous |
| est_o | output | 1 | Early steering: a valid tone pair is present |
| code_o | output | 4 | Digit code of the last pair that raised `est_o` |

## Verification
The bench walks all sixteen row/column pairs and checks each code, so a swapped row in the non-sequential fourth row or fourth column shows up at once. It tests a tone 1.4% off, which must be accepted, and one 5% off, which must be rejected; a design with the window scaled wrongly or computed from a single period fails one of the two. It also stops one tone and checks that `est_o` is still high well before 8 ms and low after it, which catches a timeout that is missing or too short. The last tests change the pair with no gap and send an out-of-band tone: a code that moves while `est_o` is low, or is cleared on loss of the pair, is reported.

// File: rtl/dtmf_pkg.sv
// Package: tone tables and digit mapping shared by the decoder.
// Assumes row/column indices 0..3 in ascending frequency order.
package dtmf_pkg;

    localparam int NUM_TONES = 4;

    // Nominal frequency in Hz of tone idx in group grp (0 = rows, 1 = columns).
    function automatic int tone_hz(input int grp, input int idx);
        int hz;
        if (grp == 0) begin
            case (idx)
                0:       hz = 697;
                1:       hz = 770;
                2:       hz = 852;
                default: hz = 941;
            endcase
        end else begin
            case (idx)
                0:       hz = 1209;
                1:       hz = 1336;
                2:       hz = 1477;
                default: hz = 1633;
            endcase
        end
        return hz;
    endfunction

    // Maps a row/column pair to its 4-bit digit code.
    function automatic logic [3:0] digit_code(input logic [1:0] row, input logic [1:0] col);
        logic [3:0] c;
        if (col == 2'd3) begin
            case (row)
                2'd0:    c = 4'b1101;
                2'd1:    c = 4'b1110;
                2'd2:    c = 4'b1111;
                default: c = 4'b0000;
            endcase
        end else if (row == 2'd3) begin
            case (col)
                2'd0:    c = 4'b1011;
                2'd1:    c = 4'b1010;
                default: c = 4'b1100;
            endcase
        end else begin
            c = 4'(row) * 4'd3 + 4'(col) + 4'd1;
        end
        return c;
    endfunction

endpackage

// File: rtl/dtmf_period_meter.sv
// Period meter: synchronises one limited tone input, counts clock cycles
// between rising edges and reports the sum of NPER consecutive periods.
// Assumes NPER is a power of two. The first edge after reset or after a
// timeout only arms the meter. No edge for CNT_MAX cycles raises lost_o once.
module dtmf_period_meter #(
    parameter int CNT_MAX = 28636,
    parameter int NPER    = 4,
    localparam int CNT_W  = $clog2(CNT_MAX + 1),
    localparam int NPW    = (NPER > 1) ? $clog2(NPER) : 1,
    localparam int SUM_W  = CNT_W + NPW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tone_i,
    output logic             done_o,
    output logic [SUM_W-1:0] sum_o,
    output logic             lost_o
);

    logic [2:0]       sync_q;
    logic [CNT_W-1:0] cnt_q;
    logic [SUM_W-1:0] acc_q;
    logic [NPW-1:0]   nper_q;
    logic             armed_q;
    logic             rise;
    logic             stall;

    assign rise  = sync_q[1] & ~sync_q[2];
    assign stall = armed_q && (cnt_q == CNT_W'(CNT_MAX));

    // Two-flop synchroniser plus one delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], tone_i};
    end

    // Period counting, accumulation over NPER periods and stall detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            acc_q   <= '0;
            nper_q  <= '0;
            armed_q <= 1'b0;
            done_o  <= 1'b0;
            sum_o   <= '0;
            lost_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            lost_o <= 1'b0;
            if (rise) begin
                cnt_q   <= CNT_W'(1);
                armed_q <= 1'b1;
                if (armed_q) begin
                    if (nper_q == NPW'(NPER - 1)) begin
                        done_o <= 1'b1;
                        sum_o  <= acc_q + SUM_W'(cnt_q);
                        acc_q  <= '0;
                        nper_q <= '0;
                    end else begin
                        acc_q  <= acc_q + SUM_W'(cnt_q);
                        nper_q <= nper_q + NPW'(1);
                    end
                end
            end else if (stall) begin
                armed_q <= 1'b0;
                acc_q   <= '0;
                nper_q  <= '0;
                lost_o  <= 1'b1;
            end else if (cnt_q != CNT_W'(CNT_MAX)) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/dtmf_tone_classifier.sv
// Tone classifier: compares each period sum with the windows of the four
// nominal tones of group GRP (0 = rows, 1 = columns) and keeps the result
// until the next sum or a stall. Assumes the windows of a group do not overlap.
module dtmf_tone_classifier
    import dtmf_pkg::*;
#(
    parameter int GRP        = 0,
    parameter int CLK_HZ     = 3579545,
    parameter int NPER       = 4,
    parameter int TOL_PERMIL = 25,
    parameter int SUM_W      = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done_i,
    input  logic [SUM_W-1:0] sum_i,
    input  logic             lost_i,
    output logic             ok_o,
    output logic [1:0]       idx_o
);

    logic [NUM_TONES-1:0] match;
    logic [1:0]           enc;

    for (genvar i = 0; i < NUM_TONES; i++) begin : g_win
        localparam longint F   = longint'(tone_hz(GRP, i));
        localparam longint NUM = longint'(NPER) * longint'(CLK_HZ) * 1000;
        localparam longint LO  = (NUM + F * (1000 + TOL_PERMIL) - 1) / (F * (1000 + TOL_PERMIL));
        localparam longint HI  = NUM / (F * (1000 - TOL_PERMIL));
        assign match[i] = (longint'(sum_i) >= LO) && (longint'(sum_i) <= HI);
    end

    // Encodes the matching window to its tone index.
    always_comb begin
        enc = 2'd0;
        for (int i = NUM_TONES - 1; i >= 0; i--) begin
            if (match[i]) enc = 2'(i);
        end
    end

    // Registers the classification of each finished sum; a stall clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ok_o  <= 1'b0;
            idx_o <= '0;
        end else if (done_i) begin
            ok_o  <= |match;
            idx_o <= enc;
        end else if (lost_i) begin
            ok_o  <= 1'b0;
        end
    end

endmodule

// File: rtl/dtmf_pair_latch.sv
// Pair latch: raises early steering when both groups match, latches the
// digit code only on that rise, and drops steering for a cycle when the
// matched pair changes so that each new code comes with a fresh rise.
module dtmf_pair_latch
    import dtmf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lo_ok_i,
    input  logic [1:0] lo_idx_i,
    input  logic       hi_ok_i,
    input  logic [1:0] hi_idx_i,
    output logic       est_o,
    output logic [3:0] code_o
);

    logic [1:0] row_q;
    logic [1:0] col_q;
    logic       same_pair;

    assign same_pair = (row_q == lo_idx_i) && (col_q == hi_idx_i);

    // Steering flag and code register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            est_o  <= 1'b0;
            code_o <= 4'b0000;
            row_q  <= '0;
            col_q  <= '0;
        end else if (lo_ok_i && hi_ok_i) begin
            if (!est_o) begin
                est_o  <= 1'b1;
                row_q  <= lo_idx_i;
                col_q  <= hi_idx_i;
                code_o <= digit_code(lo_idx_i, hi_idx_i);
            end else if (!same_pair) begin
                est_o <= 1'b0;
            end
        end else begin
            est_o <= 1'b0;
        end
    end

endmodule

// File: rtl/dtmf_pair_decoder.sv
// DTMF tone pair decoder top: one period meter and one classifier per tone
// group, followed by the pair latch. Inputs are asynchronous limited tones;
// the clock is the frequency reference.
module dtmf_pair_decoder #(
    parameter int CLK_HZ     = 3579545,
    parameter int TIMEOUT_MS = 8,
    parameter int NPER       = 4,
    parameter int TOL_PERMIL = 25
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tone_lo_i,
    input  logic       tone_hi_i,
    output logic       est_o,
    output logic [3:0] code_o
);

    localparam int TIMEOUT_CYC = int'((longint'(CLK_HZ) * TIMEOUT_MS) / 1000);
    localparam int CNT_W       = $clog2(TIMEOUT_CYC + 1);
    localparam int NPW         = (NPER > 1) ? $clog2(NPER) : 1;
    localparam int SUM_W       = CNT_W + NPW;

    logic [1:0]       tone_in;
    logic [1:0]       done;
    logic [1:0]       lost;
    logic [SUM_W-1:0] sum   [2];
    logic [1:0]       tone_ok;
    logic [1:0]       tone_idx [2];

    assign tone_in = {tone_hi_i, tone_lo_i};

    for (genvar g = 0; g < 2; g++) begin : g_grp
        dtmf_period_meter #(
            .CNT_MAX (TIMEOUT_CYC),
            .NPER    (NPER)
        ) u_meter (
            .clk    (clk),
            .rst_n  (rst_n),
            .tone_i (tone_in[g]),
            .done_o (done[g]),
            .sum_o  (sum[g]),
            .lost_o (lost[g])
        );

        dtmf_tone_classifier #(
            .GRP        (g),
            .CLK_HZ     (CLK_HZ),
            .NPER       (NPER),
            .TOL_PERMIL (TOL_PERMIL),
            .SUM_W      (SUM_W)
        ) u_class (
            .clk    (clk),
            .rst_n  (rst_n),
            .done_i (done[g]),
            .sum_i  (sum[g]),
            .lost_i (lost[g]),
            .ok_o   (tone_ok[g]),
            .idx_o  (tone_idx[g])
        );
    end

    dtmf_pair_latch u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .lo_ok_i  (tone_ok[0]),
        .lo_idx_i (tone_idx[0]),
        .hi_ok_i  (tone_ok[1]),
        .hi_idx_i (tone_idx[1]),
        .est_o    (est_o),
        .code_o   (code_o)
    );

endmodule

// File: rtl/dtmf_pair_decoder_chk.sv
// Checker for the tone pair decoder: reset values, steering against the
// per-group results, code stability and the no-edge timeout at the ports.
module dtmf_pair_decoder_chk #(
    parameter int CNT_MAX = 28636,
    localparam int GAP    = 8,
    localparam int SW     = $clog2(CNT_MAX + GAP + 1)
) (
    input logic       clk,
    input logic       rst_n,
    input logic       tone_lo_i,
    input logic       tone_hi_i,
    input logic       lo_ok,
    input logic       hi_ok,
    input logic       est_o,
    input logic [3:0] code_o
);

    logic          lo_prev, hi_prev;
    logic [SW-1:0] lo_since, hi_since;

    // Counts cycles since the last rising edge seen on each raw tone input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_prev  <= 1'b0;
            hi_prev  <= 1'b0;
            lo_since <= '0;
            hi_since <= '0;
        end else begin
            lo_prev <= tone_lo_i;
            hi_prev <= tone_hi_i;
            if (tone_lo_i && !lo_prev) lo_since <= '0;
            else if (lo_since != SW'(CNT_MAX + GAP)) lo_since <= lo_since + SW'(1);
            if (tone_hi_i && !hi_prev) hi_since <= '0;
            else if (hi_since != SW'(CNT_MAX + GAP)) hi_since <= hi_since + SW'(1);
        end
    end

    a_r1_reset_values: assert property (@(posedge clk)
        !rst_n |=> (!est_o && code_o == 4'b0000));

    a_r5_est_needs_pair: assert property (@(posedge clk) disable iff (!rst_n)
        est_o |-> $past(lo_ok && hi_ok));

    a_r10_code_only_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(est_o) |-> $stable(code_o));

    a_r9_lo_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_since == SW'(CNT_MAX + GAP)) |-> !est_o);

    a_r9_hi_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_since == SW'(CNT_MAX + GAP)) |-> !est_o);

endmodule

bind dtmf_pair_decoder dtmf_pair_decoder_chk #(
    .CNT_MAX (TIMEOUT_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tone_lo_i (tone_lo_i),
    .tone_hi_i (tone_hi_i),
    .lo_ok     (tone_ok[0]),
    .hi_ok     (tone_ok[1]),
    .est_o     (est_o),
    .code_o    (code_o)
);

// File: tb/dtmf_pair_decoder_tb.sv
// Bench for the tone pair decoder. Runs with a scaled reference clock so
// that a tone period is a few hundred cycles.
module dtmf_pair_decoder_tb;

    localparam int CLK_PERIOD = 10;
    localparam int REF_HZ     = 400000;
    localparam int SETTLE     = 5500;
    localparam int WATCHDOG   = 195000;

    localparam int ROW_HZ [4] = '{697, 770, 852, 941};
    localparam int COL_HZ [4] = '{1209, 1336, 1477, 1633};

    // Each entry: row index, column index, expected code.
    typedef struct packed {
        logic [1:0] row;
        logic [1:0] col;
        logic [3:0] code;
    } vec_t;

    localparam vec_t VECS [16] = '{
        '{2'd0, 2'd0, 4'd1},  '{2'd0, 2'd1, 4'd2},  '{2'd0, 2'd2, 4'd3},
        '{2'd1, 2'd0, 4'd4},  '{2'd1, 2'd1, 4'd5},  '{2'd1, 2'd2, 4'd6},
        '{2'd2, 2'd0, 4'd7},  '{2'd2, 2'd1, 4'd8},  '{2'd2, 2'd2, 4'd9},
        '{2'd3, 2'd1, 4'b1010}, '{2'd3, 2'd0, 4'b1011}, '{2'd3, 2'd2, 4'b1100},
        '{2'd0, 2'd3, 4'b1101}, '{2'd1, 2'd3, 4'b1110}, '{2'd2, 2'd3, 4'b1111},
        '{2'd3, 2'd3, 4'b0000}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tone_lo = 1'b0;
    logic       tone_hi = 1'b0;
    logic       est;
    logic [3:0] code;

    int half_lo = 0;
    int half_hi = 0;
    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 1'b0;

    dtmf_pair_decoder #(.CLK_HZ(REF_HZ)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tone_lo_i (tone_lo),
        .tone_hi_i (tone_hi),
        .est_o     (est),
        .code_o    (code)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Low-group square-wave source; half period 0 holds the level.
    always begin
        if (half_lo == 0) @(negedge clk);
        else begin
            repeat (half_lo) @(negedge clk);
            tone_lo = ~tone_lo;
        end
    end

    // High-group square-wave source.
    always begin
        if (half_hi == 0) @(negedge clk);
        else begin
            repeat (half_hi) @(negedge clk);
            tone_hi = ~tone_hi;
        end
    end

    function automatic int half_of(input int hz);
        return (REF_HZ + hz) / (2 * hz);
    endfunction

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected < %0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        // R1: reset state.
        wait_cyc(10);
        check("R1 est", {3'b0, est}, 4'd0);
        check("R1 code", code, 4'd0);
        rst_n = 1'b1;

        // R2/R3/R5/R6/R7/R8: every row/column pair.
        for (int v = 0; v < 16; v++) begin
            string tag;
            half_lo = half_of(ROW_HZ[VECS[v].row]);
            half_hi = half_of(COL_HZ[VECS[v].col]);
            wait_cyc(SETTLE);
            if (VECS[v].col == 2'd3)      tag = "R2/R3/R8";
            else if (VECS[v].row == 2'd3) tag = "R2/R3/R7";
            else                          tag = "R2/R3/R6";
            check({tag, " est R5"}, {3'b0, est}, 4'd1);
            check({tag, " code"}, code, VECS[v].code);
        end

        // R4: 770 Hz row 1.4% high is accepted (digit 5).
        half_lo = half_of(781);
        half_hi = half_of(1336);
        wait_cyc(SETTLE);
        check("R4 near est", {3'b0, est}, 4'd1);
        check("R4 near code", code, 4'd5);

        // R4/R11: same row 5% high is rejected; code held.
        half_lo = half_of(809);
        wait_cyc(SETTLE);
        check("R4 far est", {3'b0, est}, 4'd0);
        check("R11 far code held", code, 4'd5);

        // R10: back to digit 5, then straight to digit 9.
        half_lo = half_of(770);
        wait_cyc(SETTLE);
        check("R10 d5 code", code, 4'd5);
        half_lo = half_of(852);
        half_hi = half_of(1477);
        wait_cyc(SETTLE);
        check("R10 d9 est", {3'b0, est}, 4'd1);
        check("R10 d9 code", code, 4'd9);

        // R11: out-of-band low tone clears steering, code unchanged.
        half_lo = half_of(1000);
        wait_cyc(SETTLE);
        check("R11 est", {3'b0, est}, 4'd0);
        check("R11 code", code, 4'd9);

        // R9: stalled high tone keeps steering until 8 ms, then drops it.
        half_lo = half_of(941);
        half_hi = half_of(1633);
        wait_cyc(SETTLE);
        check("R9 pre est", {3'b0, est}, 4'd1);
        half_hi = 0;
        wait_cyc(2000);
        check("R9 early est", {3'b0, est}, 4'd1);
        check("R9 early code", code, 4'b0000);
        wait_cyc(1800);
        check("R9 late est", {3'b0, est}, 4'd0);

        // R1: reset during a valid pair.
        half_hi = half_of(1209);
        wait_cyc(SETTLE);
        check("R1 pre code", code, 4'b1011);
        rst_n = 1'b0;
        wait_cyc(3);
        check("R1 mid est", {3'b0, est}, 4'd0);
        check("R1 mid code", code, 4'd0);
        rst_n = 1'b1;

        done = 1'b1;
        finish_run();
    end

endmodule